// File: doc/BRIEF.md
# Speculative Load Queue with Store-Order Violation Detection

This block keeps the loads of an out-of-order core in a circular queue, in program order, from dispatch to commit. Loads are allowed to execute before the addresses of older stores are known, on the bet that none of those stores writes the same location. Each slot holds the load's PC, its position in the shared load/store allocation order, its address once executed, a done flag and a trap flag.

When a store's address resolves, the queue compares it against every executed load that is younger than the store. Each hit sets that load's trap flag; nothing is flushed at that point. The ROB signals when the oldest load may commit. The head slot leaves only once it is done.

If the committing load carries a trap, the block raises a flush request with that load's PC and order tag so fetch can restart from it. It then drops the trapped load and everything younger, which leaves the queue empty.

Top module: `ldq_spec_tracker`

## Requirements
- R1: After reset the queue is empty (`lq_empty`=1, `lq_full`=0) and neither `retire_valid` nor `flush_valid` is asserted.
- R2: A request on `alloc_valid` writes the tail slot, whose index is shown on `alloc_slot`. Slots fill in circular order, and `lq_full` rises after DEPTH loads. A request while full (or while a flush is raised) is dropped and changes nothing.
- R3: `exec_valid` marks the load in `exec_slot` as done and stores `exec_addr`. An exec aimed at a slot that holds no load is ignored, and a later load allocated into that slot starts out not done.
- R4: When `st_valid` is high, every load that is done, has an address equal to `st_addr`, and is younger than `st_age` gets its trap flag set.
- R5: A load that is not yet done when the store resolves, a load that is older than the store, and a load with a different address are never trapped by that store.
- R6: A load retires (`retire_valid`=1, `retire_age` = its order tag) only when it is the head, it is done, and `commit_en` is high. Otherwise retirement waits. Loads retire strictly in allocation order.
- R7: In the same cycle that a trapped load retires, `flush_valid` is 1 and `flush_pc` and `flush_age` carry that load's PC and order tag. `flush_valid` is 0 for an untrapped retirement.
- R8: A flush removes every load younger than the trapped one, so the queue is empty in the next cycle.
- R9: Order tags are an index with a wrap bit on top. Tag a is older than tag b when the wrap bits are equal and a's index is smaller, or when the wrap bits differ and a's index is larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Insert a load at the tail |
| alloc_pc | input | PC_W | PC of the inserted load |
| alloc_age | input | SEQ_IDX_W+1 | Order tag of the inserted load |
| alloc_slot | output | log2(DEPTH) | Slot index the next allocation uses |
| lq_full | output | 1 | Queue holds DEPTH loads |
| lq_empty | output | 1 | Queue holds no load |
| exec_valid | input | 1 | A load has executed |
| exec_slot | input | log2(DEPTH) | Slot of the executed load |
| exec_addr | input | ADDR_W | Address the load accessed |
| st_valid | input | 1 | A store address has resolved |
| st_addr | input | ADDR_W | Resolved store address |
| st_age | input | SEQ_IDX_W+1 | Order tag of that store |
| commit_en | input | 1 | ROB allows the oldest load to commit |
| retire_valid | output | 1 | Head load leaves the queue this cycle |
| retire_age | output | SEQ_IDX_W+1 | Order tag of the retiring load |
| flush_valid | output | 1 | Retiring load was trapped; refetch requested |
| flush_pc | output | PC_W | PC to refetch from |
| flush_age | output | SEQ_IDX_W+1 | Order tag of the trapped load |

## Verification
The bench builds the queue with DEPTH=4, SEQ_IDX_W=3, ADDR_W=8 and PC_W=8. This small size lets it sweep every store position among four loads, every subset of loads executed before the store, and every subset of matching addresses. The 4-bit order tags wrap many times during the sweep, so tag comparisons are exercised across the wrap. Because each flush moves the head to a different slot, the queue also starts from every slot.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    // Order-tag comparison: tag = {wrap, index}, index is idx_w bits wide.
    function automatic logic seq_older(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input int unsigned idx_w);
        logic [31:0] mask;
        logic [31:0] ia;
        logic [31:0] ib;
        logic        wa;
        logic        wb;
        mask = (32'h1 << idx_w) - 32'h1;
        ia   = a & mask;
        ib   = b & mask;
        wa   = a[idx_w];
        wb   = b[idx_w];
        return (wa == wb) ? (ia < ib) : (ia > ib);
    endfunction

endpackage

// File: rtl/ldq_ptr_ctl.sv
module ldq_ptr_ctl #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [IDX_W:0] head;
        logic [IDX_W:0] tail;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clear) begin
            ptr_d.head = ptr_q.head + 1'b1;
            ptr_d.tail = ptr_q.head + 1'b1;
        end else begin
            if (pop)  ptr_d.head = ptr_q.head + 1'b1;
            if (push) ptr_d.tail = ptr_q.tail + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign head_idx = ptr_q.head[IDX_W-1:0];
    assign tail_idx = ptr_q.tail[IDX_W-1:0];
    assign empty    = (ptr_q.head == ptr_q.tail);
    assign full     = (ptr_q.head[IDX_W-1:0] == ptr_q.tail[IDX_W-1:0]) &&
                      (ptr_q.head[IDX_W] != ptr_q.tail[IDX_W]);
endmodule

// File: rtl/ldq_cam.sv
module ldq_cam
    import ldq_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEQ_IDX_W = 6,
    localparam int SEQ_W    = SEQ_IDX_W + 1
) (
    input  logic                          st_valid,
    input  logic [ADDR_W-1:0]             st_addr,
    input  logic [SEQ_W-1:0]              st_age,
    input  logic [DEPTH-1:0]              ent_vld,
    input  logic [DEPTH-1:0]              ent_done,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [DEPTH-1:0][SEQ_W-1:0]   ent_age,
    output logic [DEPTH-1:0]              hit
);
    localparam int PAD = 32 - SEQ_W;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic younger;
        assign younger = seq_older({{PAD{1'b0}}, st_age},
                                   {{PAD{1'b0}}, ent_age[i]},
                                   SEQ_IDX_W);
        assign hit[i] = st_valid && ent_vld[i] && ent_done[i] &&
                        (ent_addr[i] == st_addr) && younger;
    end
endmodule

// File: rtl/ldq_spec_tracker.sv
module ldq_spec_tracker #(
    parameter int DEPTH     = 32,
    parameter int SEQ_IDX_W = 6,
    parameter int ADDR_W    = 32,
    parameter int PC_W      = 32,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int SEQ_W    = SEQ_IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic [SEQ_W-1:0]  alloc_age,
    output logic [IDX_W-1:0]  alloc_slot,
    output logic              lq_full,
    output logic              lq_empty,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_slot,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SEQ_W-1:0]  st_age,
    input  logic              commit_en,
    output logic              retire_valid,
    output logic [SEQ_W-1:0]  retire_age,
    output logic              flush_valid,
    output logic [PC_W-1:0]   flush_pc,
    output logic [SEQ_W-1:0]  flush_age
);
    typedef struct packed {
        logic              vld;
        logic              done;
        logic              trap;
        logic [ADDR_W-1:0] addr;
        logic [PC_W-1:0]   pc;
        logic [SEQ_W-1:0]  age;
    } ent_t;

    ent_t ent_q [DEPTH];
    ent_t ent_d [DEPTH];

    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;
    logic             push;
    logic             pop;

    logic [DEPTH-1:0]             v_vld;
    logic [DEPTH-1:0]             v_done;
    logic [DEPTH-1:0][ADDR_W-1:0] v_addr;
    logic [DEPTH-1:0][SEQ_W-1:0]  v_age;
    logic [DEPTH-1:0]             hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign v_vld[i]  = ent_q[i].vld;
        assign v_done[i] = ent_q[i].done;
        assign v_addr[i] = ent_q[i].addr;
        assign v_age[i]  = ent_q[i].age;
    end

    ldq_cam #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_IDX_W(SEQ_IDX_W)
    ) u_cam (
        .st_valid(st_valid), .st_addr(st_addr), .st_age(st_age),
        .ent_vld(v_vld), .ent_done(v_done), .ent_addr(v_addr),
        .ent_age(v_age), .hit(hit)
    );

    ldq_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .clear(flush_valid), .head_idx(head_idx), .tail_idx(tail_idx),
        .empty(lq_empty), .full(lq_full)
    );

    // Head view and retirement decision
    always_comb begin
        ent_t h;
        h            = ent_q[head_idx];
        pop          = h.vld && h.done && commit_en;
        retire_valid = pop;
        retire_age   = h.age;
        flush_valid  = pop && h.trap;
        flush_pc     = h.pc;
        flush_age    = h.age;
        push         = alloc_valid && !lq_full && !flush_valid;
        alloc_slot   = tail_idx;
    end

    // Next-state of the entry array
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
            if (hit[i]) ent_d[i].trap = 1'b1;
        end
        if (exec_valid && ent_q[exec_slot].vld) begin
            ent_d[exec_slot].done = 1'b1;
            ent_d[exec_slot].addr = exec_addr;
        end
        if (pop) ent_d[head_idx].vld = 1'b0;
        if (push) begin
            ent_d[tail_idx].vld  = 1'b1;
            ent_d[tail_idx].done = 1'b0;
            ent_d[tail_idx].trap = 1'b0;
            ent_d[tail_idx].addr = '0;
            ent_d[tail_idx].pc   = alloc_pc;
            ent_d[tail_idx].age  = alloc_age;
        end
        if (flush_valid) begin
            for (int i = 0; i < DEPTH; i++) ent_d[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end
endmodule

// File: rtl/ldq_spec_tracker_chk.sv
module ldq_spec_tracker_chk #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lq_full,
    input logic             lq_empty,
    input logic [IDX_W-1:0] alloc_slot,
    input logic             commit_en,
    input logic             retire_valid,
    input logic             flush_valid
);
    a_r1_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(lq_full && lq_empty));

    a_r2_full_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && !retire_valid) |=> (lq_full && $stable(alloc_slot)));

    a_r6_retire_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (commit_en && !lq_empty));

    a_r7_flush_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> retire_valid);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> lq_empty);
endmodule

bind ldq_spec_tracker ldq_spec_tracker_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/ldq_spec_tracker_tb.sv
`timescale 1ns/1ps
module ldq_spec_tracker_tb;
    localparam int DEPTH = 4;
    localparam int SIW   = 3;
    localparam int AW    = 8;
    localparam int PW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [PW-1:0] alloc_pc = '0;
    logic [SIW:0]  alloc_age = '0;
    logic [1:0]    alloc_slot;
    logic          lq_full, lq_empty;
    logic          exec_valid = 1'b0;
    logic [1:0]    exec_slot = '0;
    logic [AW-1:0] exec_addr = '0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [SIW:0]  st_age = '0;
    logic          commit_en = 1'b0;
    logic          retire_valid;
    logic [SIW:0]  retire_age;
    logic          flush_valid;
    logic [PW-1:0] flush_pc;
    logic [SIW:0]  flush_age;

    int checks = 0;
    int errors = 0;
    int cur_seq = 0;
    int base = 0;

    always #2.5 clk = ~clk;

    ldq_spec_tracker #(.DEPTH(DEPTH), .SEQ_IDX_W(SIW), .ADDR_W(AW), .PC_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_pc(alloc_pc),
        .alloc_age(alloc_age), .alloc_slot(alloc_slot), .lq_full(lq_full),
        .lq_empty(lq_empty), .exec_valid(exec_valid), .exec_slot(exec_slot),
        .exec_addr(exec_addr), .st_valid(st_valid), .st_addr(st_addr),
        .st_age(st_age), .commit_en(commit_en), .retire_valid(retire_valid),
        .retire_age(retire_age), .flush_valid(flush_valid), .flush_pc(flush_pc),
        .flush_age(flush_age)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge, then settle.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [SIW:0] tg(input int x);
        return x[SIW:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pcs [4];
        int addrs [4];
        logic trapped [4];
        logic [7:0] a_base;
        bit stop;

        repeat (3) cyc();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 empty", lq_empty, 1);
        chk("R1 full", lq_full, 0);
        chk("R1 retire", retire_valid, 0);
        chk("R1 flush", flush_valid, 0);

        // R3: exec on an empty slot is ignored
        exec_valid = 1'b1; exec_slot = 2'd0; exec_addr = 8'h55;
        cyc();
        exec_valid = 1'b0;
        alloc_valid = 1'b1; alloc_pc = 8'h11; alloc_age = tg(cur_seq);
        #1;
        chk("R2 first slot", alloc_slot, 0);
        cyc();
        alloc_valid = 1'b0;
        commit_en = 1'b1;
        #1;
        chk("R3 stale exec ignored", retire_valid, 0);
        chk("R6 head not done waits", lq_empty, 0);
        cyc();
        commit_en = 1'b0;
        exec_valid = 1'b1; exec_slot = 2'd0; exec_addr = 8'h55;
        cyc();
        exec_valid = 1'b0;
        commit_en = 1'b1;
        #1;
        chk("R6 done head retires", retire_valid, 1);
        chk("R6 retire age", retire_age, tg(cur_seq));
        chk("R7 no flush untrapped", flush_valid, 0);
        cyc();
        commit_en = 1'b0;
        chk("R6 empty after retire", lq_empty, 1);
        cur_seq += 1;
        base = 1;

        // R2: allocation when full is dropped
        for (int k = 0; k < 5; k++) begin
            alloc_valid = 1'b1; alloc_pc = 8'h20 + 8'(k); alloc_age = tg(cur_seq + k);
            #1;
            if (k < 4) chk("R2 slot order", alloc_slot, (base + k) % 4);
            else begin
                chk("R2 full", lq_full, 1);
                chk("R2 slot frozen", alloc_slot, base);
            end
            cyc();
        end
        alloc_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            exec_valid = 1'b1; exec_slot = 2'((base + k) % 4); exec_addr = 8'h30;
            cyc();
        end
        exec_valid = 1'b0;
        commit_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R6 in-order retire", retire_valid, 1);
            chk("R6 in-order age", retire_age, tg(cur_seq + k));
            cyc();
        end
        #1;
        chk("R2 dropped alloc absent", retire_valid, 0);
        chk("R2 empty", lq_empty, 1);
        commit_en = 1'b0;
        cur_seq += 5;

        // Sweep: store position p, early-exec mask em, address-match mask mm
        for (int p = 0; p < 5; p++) begin
            for (int em = 0; em < 16; em++) begin
                for (int mm = 0; mm < 16; mm++) begin
                    int s;
                    s = cur_seq;
                    cur_seq += 9;
                    a_base = 8'h40 + 8'(p * 7 + em);
                    for (int k = 0; k < 4; k++) begin
                        pcs[k] = (s * 4 + k) % 256;
                        addrs[k] = mm[k] ? int'(a_base) : int'(a_base ^ 8'(k + 1));
                        trapped[k] = em[k] && mm[k] && (k >= p);
                        alloc_valid = 1'b1; alloc_pc = 8'(pcs[k]);
                        alloc_age = tg(s + 2 * k + 1);
                        #1;
                        chk("R2 sweep slot", alloc_slot, (base + k) % 4);
                        cyc();
                    end
                    alloc_valid = 1'b0;
                    chk("R2 sweep full", lq_full, 1);
                    for (int k = 0; k < 4; k++) begin
                        if (em[k]) begin
                            exec_valid = 1'b1; exec_slot = 2'((base + k) % 4);
                            exec_addr = 8'(addrs[k]);
                            cyc();
                        end
                    end
                    exec_valid = 1'b0;
                    if (!em[0]) begin
                        commit_en = 1'b1;
                        #1;
                        chk("R6 wait for undone head", retire_valid, 0);
                        cyc();
                        commit_en = 1'b0;
                    end
                    // R4/R5/R9 store resolves at tag s+2p
                    st_valid = 1'b1; st_addr = a_base; st_age = tg(s + 2 * p);
                    cyc();
                    st_valid = 1'b0;
                    for (int k = 0; k < 4; k++) begin
                        if (!em[k]) begin
                            exec_valid = 1'b1; exec_slot = 2'((base + k) % 4);
                            exec_addr = 8'(addrs[k]);
                            cyc();
                        end
                    end
                    exec_valid = 1'b0;
                    commit_en = 1'b1;
                    stop = 1'b0;
                    for (int k = 0; k < 4; k++) begin
                        if (!stop) begin
                            alloc_valid = trapped[k]; alloc_pc = 8'hEE; alloc_age = tg(s + 8);
                            #1;
                            chk("R6 sweep retire", retire_valid, 1);
                            chk("R6 sweep age", retire_age, tg(s + 2 * k + 1));
                            chk("R4 R5 trap decision", flush_valid, trapped[k]);
                            if (trapped[k]) begin
                                chk("R7 flush pc", flush_pc, pcs[k]);
                                chk("R7 flush age", flush_age, tg(s + 2 * k + 1));
                            end
                            cyc();
                            alloc_valid = 1'b0;
                            if (trapped[k]) begin
                                chk("R8 flush empties", lq_empty, 1);
                                base = (base + k + 1) % 4;
                                stop = 1'b1;
                            end
                        end
                    end
                    commit_en = 1'b0;
                    #1;
                    chk("R8 empty at end", lq_empty, 1);
                    chk("R9 no stray retire", retire_valid, 0);
                end
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule